// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit decodes one 32-bit instruction word per clock, works out whether it is a branch, whether that branch is taken, and which address the program counter moves to next. The top six bits carry the opcode. Bits 25:21 name the register under test. The low 21 bits hold a signed displacement counted in 4-byte words. The caller supplies the value of the tested register and the current PC along with the instruction word. The unit then evaluates the condition selected by the opcode on that value: a sign test, a zero test or a low-bit parity test.

All results are registered, so they appear one clock after the inputs are presented. A branch that is taken goes to a PC-relative target built from the fall-through address. Anything that is not taken, including a non-branch word, falls through to PC+4. The two unconditional opcodes are always taken. They also raise a link-write flag so that the caller can store the fall-through address as a return value.

Top module: `branch_unit`

## Requirements
- R1: While reset (`rstN` low) is asserted, `isBranch`, `branchTaken`, `writeLink`, `nextPc` and `retPc` all read zero.
- R2: Every output shows the instruction, PC and operand that were presented at the preceding rising clock edge, with exactly one cycle of latency.
- R3: `isBranch` is 1 exactly for opcodes (bits 31:26) 0x30, 0x34 and 0x38 through 0x3F. Every other opcode gives 0.
- R4: Opcodes 0x30 and 0x34 are unconditional: `branchTaken` and `writeLink` are both 1, whatever the operand holds.
- R5: The conditional opcodes treat the operand as two's complement and are taken when: 0x39 equals zero, 0x3D is not zero, 0x3A is below zero, 0x3B is at or below zero, 0x3F is above zero, 0x3E is at or above zero, 0x38 has bit 0 clear, 0x3C has bit 0 set.
- R6: When a branch is taken, `nextPc` = PC + 4 + (sign-extended bits 20:0 × 4), wrapping modulo 2^PC_W.
- R7: When no branch is taken, including every non-branch opcode, `branchTaken` is 0 and `nextPc` = PC + 4.
- R8: `retPc` is always PC + 4, wrapping modulo 2^PC_W. `writeLink` is 1 only for the unconditional opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| instrWord | input | 32 | Instruction word to decode |
| curPc | input | PC_W | Address of the instruction |
| regValue | input | DATA_W | Value of the tested register |
| isBranch | output | 1 | The word was a branch opcode |
| branchTaken | output | 1 | The branch is taken |
| nextPc | output | PC_W | Address of the next instruction |
| retPc | output | PC_W | Fall-through address PC+4 |
| writeLink | output | 1 | Store `retPc` as a return value |

## Verification
The assertions check, on every cycle, four invariants that hold between the registered outputs and the decoder's strobes. A taken result always comes from a branch opcode. A link write always comes with a taken branch. A result that is not taken always points `nextPc` at the fall-through address. An unconditional strobe always implies a branch strobe. Whether each condition reads the sign, zero and low-bit properties of the operand correctly, and whether the displacement is scaled and sign-extended correctly (including wrap-around near address zero and the most negative and most positive displacements), can only be shown by the bench's scenarios, which compare against a behavioural model on every clock.

// File: rtl/branch_pkg.sv
package branch_pkg;
  typedef enum logic [2:0] {
    C_EQZ, C_NEZ, C_LTZ, C_LEZ, C_GTZ, C_GEZ, C_LOWCLR, C_LOWSET
  } condSel_t;

  typedef struct packed {
    logic     isBranch;
    logic     isUncond;
    condSel_t cond;
  } branchStrobes_t;

  localparam int unsigned OPC_W  = 6;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned DISP_W = 21;
endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output branchStrobes_t   strobes
);
  always_comb begin
    strobes = '{isBranch: 1'b0, isUncond: 1'b0, cond: C_EQZ};
    unique case (opcode)
      6'h30, 6'h34: begin strobes.isBranch = 1'b1; strobes.isUncond = 1'b1; end
      6'h38: begin strobes.isBranch = 1'b1; strobes.cond = C_LOWCLR; end
      6'h39: begin strobes.isBranch = 1'b1; strobes.cond = C_EQZ;    end
      6'h3A: begin strobes.isBranch = 1'b1; strobes.cond = C_LTZ;    end
      6'h3B: begin strobes.isBranch = 1'b1; strobes.cond = C_LEZ;    end
      6'h3C: begin strobes.isBranch = 1'b1; strobes.cond = C_LOWSET; end
      6'h3D: begin strobes.isBranch = 1'b1; strobes.cond = C_NEZ;    end
      6'h3E: begin strobes.isBranch = 1'b1; strobes.cond = C_GEZ;    end
      6'h3F: begin strobes.isBranch = 1'b1; strobes.cond = C_GTZ;    end
      default: ;
    endcase
  end

  // R4: an unconditional strobe must come with a branch strobe
  always_comb begin
    if (!$isunknown(opcode))
      p_uncond_isbr_r4: assert (!strobes.isUncond || strobes.isBranch)
        else $error("unconditional strobe without branch strobe");
  end
endmodule

// File: rtl/branch_datapath.sv
module branch_datapath
  import branch_pkg::*;
#(
  parameter int unsigned PC_W   = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  branchStrobes_t    strobes,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DATA_W-1:0] regValue,
  output logic              isBranchQ,
  output logic              takenQ,
  output logic [PC_W-1:0]   nextPcQ,
  output logic [PC_W-1:0]   retPcQ,
  output logic              linkQ
);
  localparam int unsigned SCALED_W = DISP_W + 2;
  localparam int unsigned EXT_W    = PC_W - SCALED_W;

  logic [PC_W-1:0] pcPlus4, offset, target;
  logic            isZero, isNeg, condHolds, takeNow;

  assign pcPlus4 = curPc + PC_W'(4);
  assign offset  = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign target  = pcPlus4 + offset;
  assign isZero  = (regValue == '0);
  assign isNeg   = regValue[DATA_W-1];

  always_comb begin
    unique case (strobes.cond)
      C_EQZ:    condHolds = isZero;
      C_NEZ:    condHolds = !isZero;
      C_LTZ:    condHolds = isNeg;
      C_LEZ:    condHolds = isNeg || isZero;
      C_GTZ:    condHolds = !isNeg && !isZero;
      C_GEZ:    condHolds = !isNeg;
      C_LOWCLR: condHolds = !regValue[0];
      C_LOWSET: condHolds = regValue[0];
      default:  condHolds = 1'b0;
    endcase
  end

  assign takeNow = strobes.isBranch && (strobes.isUncond || condHolds);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isBranchQ <= 1'b0;
      takenQ    <= 1'b0;
      linkQ     <= 1'b0;
      nextPcQ   <= '0;
      retPcQ    <= '0;
    end else begin
      isBranchQ <= strobes.isBranch;
      takenQ    <= takeNow;
      linkQ     <= strobes.isBranch && strobes.isUncond;
      nextPcQ   <= takeNow ? target : pcPlus4;
      retPcQ    <= pcPlus4;
    end
  end

  // R7: nothing but a branch may be taken
  p_taken_needs_branch_r7: assert property (@(posedge clk) disable iff (!rstN)
    takenQ |-> isBranchQ);
  // R4: a link write always belongs to a taken branch
  p_link_taken_r4: assert property (@(posedge clk) disable iff (!rstN)
    linkQ |-> (takenQ && isBranchQ));
  // R7: a result that is not taken falls through to the return address
  p_fallthrough_r7: assert property (@(posedge clk) disable iff (!rstN)
    !takenQ |-> (nextPcQ == retPcQ));
  // R2: an unconditional strobe yields a taken result one cycle later
  p_uncond_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.isUncond && strobes.isBranch) |=> takenQ);
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
#(
  parameter int unsigned PC_W   = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instrWord,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DATA_W-1:0] regValue,
  output logic              isBranch,
  output logic              branchTaken,
  output logic [PC_W-1:0]   nextPc,
  output logic [PC_W-1:0]   retPc,
  output logic              writeLink
);
  branchStrobes_t strobes;

  branch_ctrl i_ctrl (
    .opcode  (instrWord[31:26]),
    .strobes (strobes)
  );

  branch_datapath #(.PC_W(PC_W), .DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .disp      (instrWord[DISP_W-1:0]),
    .curPc     (curPc),
    .regValue  (regValue),
    .isBranchQ (isBranch),
    .takenQ    (branchTaken),
    .nextPcQ   (nextPc),
    .retPcQ    (retPc),
    .linkQ     (writeLink)
  );
endmodule

// File: tb/test_branch_unit.sv
module test_branch_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] curPc = '0;
  logic [63:0] regValue = '0;
  logic        isBranch, branchTaken, writeLink;
  logic [63:0] nextPc, retPc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] qNext[$], qRet[$];
  logic        qBr[$], qTk[$], qLk[$];
  string       qTag[$];

  always #2 clk = ~clk;

  branch_unit i_branch_unit (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .curPc(curPc),
    .regValue(regValue), .isBranch(isBranch), .branchTaken(branchTaken),
    .nextPc(nextPc), .retPc(retPc), .writeLink(writeLink)
  );

  task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: computes expectations and queues them
  task automatic present(input logic [5:0] opc, input logic [20:0] disp,
                         input logic [63:0] pc, input logic [63:0] val, input string tag);
    longint sv = val;
    longint d;
    logic br, un, tk;
    logic [63:0] fall;
    instrWord = {opc, 5'd7, disp};
    curPc = pc;
    regValue = val;
    d = longint'(signed'(disp));
    fall = pc + 64'd4;
    un = (opc == 6'h30) || (opc == 6'h34);
    br = un || (opc >= 6'h38);
    case (opc)
      6'h39: tk = (sv == 0);
      6'h3D: tk = (sv != 0);
      6'h3A: tk = (sv < 0);
      6'h3B: tk = (sv <= 0);
      6'h3F: tk = (sv > 0);
      6'h3E: tk = (sv >= 0);
      6'h38: tk = (val % 2 == 0);
      6'h3C: tk = (val % 2 == 1);
      default: tk = un;
    endcase
    qBr.push_back(br); qTk.push_back(tk); qLk.push_back(un);
    qRet.push_back(fall);
    qNext.push_back(tk ? fall + 64'(d * 4) : fall);
    qTag.push_back(tag);
  endtask

  task automatic compareNow();
    string t;
    if (qTag.size() == 0) return;
    t = qTag.pop_front();
    check1({t, "/R3"}, 64'(isBranch), 64'(qBr.pop_front()), "isBranch");
    check1(t, 64'(branchTaken), 64'(qTk.pop_front()), "branchTaken");
    check1({t, "/R8"}, 64'(writeLink), 64'(qLk.pop_front()), "writeLink");
    check1({t, "/R8"}, retPc, qRet.pop_front(), "retPc");
    check1(t, nextPc, qNext.pop_front(), "nextPc");
  endtask

  task automatic step(input logic [5:0] opc, input logic [20:0] disp,
                      input logic [63:0] pc, input logic [63:0] val, input string tag);
    @(negedge clk);
    compareNow();
    present(opc, disp, pc, val, tag);
  endtask

  initial begin
    logic [5:0] conds [8] = '{6'h38, 6'h39, 6'h3A, 6'h3B, 6'h3C, 6'h3D, 6'h3E, 6'h3F};
    logic [63:0] vals [6] = '{64'd0, 64'd1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF,
                              64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFE};
    repeat (3) @(negedge clk);
    // R1: reset state, with live inputs applied
    instrWord = 32'hC000_0010; curPc = 64'h1000; regValue = 64'd5;
    @(negedge clk);
    check1("R1", 64'(isBranch), 0, "isBranch");
    check1("R1", 64'(branchTaken), 0, "branchTaken");
    check1("R1", 64'(writeLink), 0, "writeLink");
    check1("R1", nextPc, 0, "nextPc");
    check1("R1", retPc, 0, "retPc");
    rstN = 1'b1;
    present(6'h30, 21'h10, 64'h1000, 64'd0, "R4");
    // R4 unconditional, any operand
    step(6'h34, 21'h1FFFFF, 64'h2000, 64'h8000_0000_0000_0000, "R4");
    step(6'h30, 21'h0, 64'h3000, 64'd0, "R4");
    // R5 every condition against each operand pattern
    foreach (conds[c])
      foreach (vals[v])
        step(conds[c], 21'h40, 64'h0001_0000 + 64'(c * 256), vals[v], "R5");
    // R6 displacement extremes and wrap-around
    step(6'h39, 21'h0FFFFF, 64'h4000, 64'd0, "R6");
    step(6'h39, 21'h100000, 64'h0100_0000, 64'd0, "R6");
    step(6'h39, 21'h1FFFFE, 64'h4, 64'd0, "R6");
    step(6'h30, 21'h000002, 64'hFFFF_FFFF_FFFF_FFFC, 64'd0, "R6");
    // R7 non-branch opcodes and untaken branches fall through
    step(6'h00, 21'h0FFFFF, 64'h5000, 64'd0, "R7");
    step(6'h31, 21'h000100, 64'h5004, 64'd0, "R7");
    step(6'h2F, 21'h1FFFFF, 64'h5008, 64'd0, "R7");
    step(6'h37, 21'h000004, 64'hFFFF_FFFF_FFFF_FFFC, 64'd0, "R7");
    step(6'h3D, 21'h000100, 64'h500C, 64'd0, "R7");
    // R2 back-to-back changing stimulus
    for (int i = 0; i < 300; i++)
      step(6'($urandom), 21'($urandom), {$urandom, $urandom & 32'hFFFF_FFFC},
           (i % 3 == 0) ? 64'(i % 2) : {$urandom, $urandom}, "R2");
    @(negedge clk);
    compareNow();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule